// File: doc/BRIEF.md
# H6 Inverter Gate Pattern Generator

This block produces the six gate-drive bits for a single-phase, transformerless H6 full bridge modulated with unipolar sinusoidal PWM. An internal symmetric up/down counter forms the triangular carrier. The magnitude of a signed current-reference sample is compared with that carrier on every clock. The result selects between an active state and a freewheeling state. The sign of the reference selects the half-cycle. Together they pick one of four switch sets, and the bridge is cut off from the array whenever the output sits at zero volts.

In each half-cycle one switch is held on throughout, and a pair of switches chops at the carrier rate. The polarity follows the current reference, not the grid voltage, so the pattern also works when current and voltage are out of phase. A new polarity is adopted only when the carrier is at zero. Every gate turn-on is held back by a programmable dead time, and every turn-off takes effect at once. The registered two-bit mode output stays aligned with the gate register.

Top module: `h6_gate_gen`

## Requirements
- R1: While `rst` is high, all six gates are off after the next clock edge and `mode_o` reads 1.
- R2: Positive half-cycle, active (mode code 0): S1, S4 and S5 are on, so `gate_o` = 6'b011001 (bit 0 is S1, up to bit 5 for S6).
- R3: Positive half-cycle, freewheeling (mode code 1): only S1 is on, so `gate_o` = 6'b000001.
- R4: Negative half-cycle, active (mode code 2): S2, S3 and S6 are on, so `gate_o` = 6'b100110.
- R5: Negative half-cycle, freewheeling (mode code 3): only S3 is on, so `gate_o` = 6'b000100.
- R6: The carrier starts at 0 and steps by one per clock up to `peak_i`, then back down to 0. The state is active when |`ref_i`| is strictly greater than the carrier value and freewheeling otherwise, and the most negative reference counts as its full magnitude.
- R7: The polarity is negative when `ref_i` is below zero. It is sampled only in a cycle where the carrier equals 0 and is held at every other carrier value.
- R8: A gate whose pattern bit goes high turns on `dead_i` clocks later than it would with zero dead time. A gate whose pattern bit goes low turns off on the next clock edge.
- R9: S1 and S2 are never on together, and S3 and S4 are never on together.
- R10: One clock edge after `en` is low, all gates are off, `mode_o` reads 1, and the carrier is held at 0.
- R11: With zero dead time, `mode_o` and `gate_o` change on the same clock edge, one edge after the inputs that decide them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Modulator enable |
| ref_i | input | REF_W | Signed current-reference sample |
| peak_i | input | CNT_W | Carrier peak value (half-period in clocks) |
| dead_i | input | DT_W | Turn-on delay in clocks |
| gate_o | output | 6 | Gate bits, bit 0 = S1 to bit 5 = S6 |
| mode_o | output | 2 | Mode code 0..3 (positive active, positive freewheel, negative active, negative freewheel) |

## Verification
Constant references are held over many carrier periods: a mid-range positive value, a small negative value, zero, values at and above the peak, and the most negative code. These separate the strict comparison at the carrier top and bottom and the magnitude of the most negative input. Random references, each held for a random time, cross zero at arbitrary carrier phases, which shows whether the polarity is sampled only at the valley. Random dead-time settings and enable drops then separate delayed turn-on from immediate turn-off and from the forced-off state. A second, shorter carrier peak checks that the triangle follows its programmed limit.

// File: rtl/h6_pkg.sv
package h6_pkg;
  localparam int NUM_SW = 6;

  typedef enum logic [1:0] {
    MODE_POS_ACT = 2'd0,
    MODE_POS_FW  = 2'd1,
    MODE_NEG_ACT = 2'd2,
    MODE_NEG_FW  = 2'd3
  } h6_mode_e;

  // switch set per mode, bit 0 = S1 ... bit 5 = S6
  function automatic logic [NUM_SW-1:0] sw_pattern(h6_mode_e m);
    case (m)
      MODE_POS_ACT: sw_pattern = 6'b011001;
      MODE_POS_FW:  sw_pattern = 6'b000001;
      MODE_NEG_ACT: sw_pattern = 6'b100110;
      default:      sw_pattern = 6'b000100;
    endcase
  endfunction
endpackage

// File: rtl/h6_tri_carrier.sv
module h6_tri_carrier #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] peak_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             valley_o
);
  logic rising;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_o  <= '0;
      rising <= 1'b1;
    end else if (rising) begin
      if (cnt_o >= peak_i) begin
        rising <= 1'b0;
        if (cnt_o != '0) cnt_o <= cnt_o - 1'b1;
      end else begin
        cnt_o <= cnt_o + 1'b1;
      end
    end else begin
      if (cnt_o == '0) begin
        rising <= 1'b1;
        if (peak_i != '0) cnt_o <= cnt_o + 1'b1;
      end else begin
        cnt_o <= cnt_o - 1'b1;
      end
    end
  end

  assign valley_o = (cnt_o == '0);
endmodule

// File: rtl/h6_mode_pick.sv
module h6_mode_pick
  import h6_pkg::*;
#(
  parameter int REF_W = 12,
  parameter int CNT_W = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic signed [REF_W-1:0] ref_i,
  input  logic [CNT_W-1:0]        cnt_i,
  input  logic                    valley_i,
  output h6_mode_e                mode_o,
  output logic [NUM_SW-1:0]       pat_o
);
  localparam int CMP_W = (REF_W > CNT_W) ? REF_W : CNT_W;

  logic             neg_q;
  logic             neg_eff;
  logic [REF_W-1:0] mag;
  logic [CMP_W-1:0] mag_x;
  logic [CMP_W-1:0] cnt_x;
  logic             active;

  // polarity only re-sampled at the carrier valley
  assign neg_eff = valley_i ? ref_i[REF_W-1] : neg_q;

  always_ff @(posedge clk) begin
    if (rst) neg_q <= 1'b0;
    else     neg_q <= neg_eff;
  end

  always_comb begin
    if (ref_i[REF_W-1]) mag = $unsigned(-ref_i);
    else                mag = $unsigned(ref_i);
    mag_x  = CMP_W'(mag);
    cnt_x  = CMP_W'(cnt_i);
    active = (mag_x > cnt_x);
    if (!en)        mode_o = MODE_POS_FW;
    else if (neg_eff) mode_o = active ? MODE_NEG_ACT : MODE_NEG_FW;
    else              mode_o = active ? MODE_POS_ACT : MODE_POS_FW;
    pat_o = en ? sw_pattern(mode_o) : '0;
  end
endmodule

// File: rtl/h6_rise_delay.sv
module h6_rise_delay #(
  parameter int DT_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_i,
  input  logic [DT_W-1:0] dead_i,
  output logic            gate_o
);
  logic [DT_W-1:0] wait_q;

  always_ff @(posedge clk) begin
    if (rst || !req_i) begin
      gate_o <= 1'b0;
      wait_q <= '0;
    end else if (wait_q >= dead_i) begin
      gate_o <= 1'b1;
    end else begin
      wait_q <= wait_q + 1'b1;
    end
  end
endmodule

// File: rtl/h6_gate_gen.sv
module h6_gate_gen
  import h6_pkg::*;
#(
  parameter int REF_W = 12,
  parameter int CNT_W = 12,
  parameter int DT_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic signed [REF_W-1:0] ref_i,
  input  logic [CNT_W-1:0]        peak_i,
  input  logic [DT_W-1:0]         dead_i,
  output logic [5:0]              gate_o,
  output logic [1:0]              mode_o
);
  logic [CNT_W-1:0]  car_cnt;
  logic              car_valley;
  h6_mode_e          mode_c;
  logic [NUM_SW-1:0] pat_c;

  h6_tri_carrier #(.CNT_W(CNT_W)) i_carrier (
    .clk(clk), .rst(rst), .run(en), .peak_i(peak_i),
    .cnt_o(car_cnt), .valley_o(car_valley)
  );

  h6_mode_pick #(.REF_W(REF_W), .CNT_W(CNT_W)) i_pick (
    .clk(clk), .rst(rst), .en(en), .ref_i(ref_i),
    .cnt_i(car_cnt), .valley_i(car_valley),
    .mode_o(mode_c), .pat_o(pat_c)
  );

  for (genvar s = 0; s < NUM_SW; s++) begin : g_sw
    h6_rise_delay #(.DT_W(DT_W)) i_dly (
      .clk(clk), .rst(rst), .req_i(pat_c[s]),
      .dead_i(dead_i), .gate_o(gate_o[s])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) mode_o <= MODE_POS_FW;
    else     mode_o <= mode_c;
  end
endmodule

// File: rtl/h6_gate_chk.sv
module h6_gate_chk (
  input logic       clk,
  input logic       rst,
  input logic       en,
  input logic [5:0] gate_o,
  input logic [1:0] mode_o
);
  // R9
  s1_s2_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(gate_o[0] && gate_o[1]));
  // R9
  s3_s4_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(gate_o[2] && gate_o[3]));
  // R10
  dis_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (gate_o == 6'b000000 && mode_o == 2'd1));
  // R2
  pos_act_set_chk: assert property (@(posedge clk) disable iff (rst)
    mode_o == 2'd0 |-> (gate_o & 6'b100110) == 6'b000000);
  // R3
  pos_fw_set_chk: assert property (@(posedge clk) disable iff (rst)
    mode_o == 2'd1 |-> (gate_o & 6'b111110) == 6'b000000);
  // R4
  neg_act_set_chk: assert property (@(posedge clk) disable iff (rst)
    mode_o == 2'd2 |-> (gate_o & 6'b011001) == 6'b000000);
  // R5
  neg_fw_set_chk: assert property (@(posedge clk) disable iff (rst)
    mode_o == 2'd3 |-> (gate_o & 6'b111011) == 6'b000000);
endmodule

bind h6_gate_gen h6_gate_chk i_gate_chk (
  .clk(clk), .rst(rst), .en(en), .gate_o(gate_o), .mode_o(mode_o)
);

// File: tb/test_h6_gate_gen.sv
module test_h6_gate_gen;
  localparam int REF_W = 12;
  localparam int CNT_W = 12;
  localparam int DT_W  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic signed [REF_W-1:0] ref_s = '0;
  logic [CNT_W-1:0] peak = 12'd20;
  logic [DT_W-1:0]  dead = '0;
  logic [5:0] gate;
  logic [1:0] mode;

  always #5 clk = ~clk;

  h6_gate_gen #(.REF_W(REF_W), .CNT_W(CNT_W), .DT_W(DT_W)) i_h6_gate_gen (
    .clk(clk), .rst(rst), .en(en), .ref_i(ref_s), .peak_i(peak),
    .dead_i(dead), .gate_o(gate), .mode_o(mode)
  );

  int checks = 0;
  int fails  = 0;
  bit started = 0;
  bit done = 0;

  // bench model state
  int mcnt = 0;
  bit mup = 1;
  bit mpol = 0;
  logic [1:0] em = 2'd1;
  logic [5:0] eg = '0;
  logic [5:0] epat = '0;
  int dc[6];
  string tag = "R1";
  bit r11_ok = 0;
  int mag;
  bit polc, act;
  logic [1:0] md;

  function automatic logic [5:0] pat_of(logic [1:0] c);
    case (c)
      2'd0: return 6'b011001;
      2'd1: return 6'b000001;
      2'd2: return 6'b100110;
      default: return 6'b000100;
    endcase
  endfunction

  task automatic chk(bit ok, string rq, int act_v, int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act_v, exp_v, $time);
    end
  endtask

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      mcnt = 0; mup = 1; mpol = 0; em = 2'd1; eg = '0; epat = '0;
      for (int i = 0; i < 6; i++) dc[i] = 0;
      tag = "R1"; r11_ok = 0;
    end else begin
      polc = (mcnt == 0) ? (ref_s < 0) : mpol;
      mag  = (ref_s < 0) ? -int'(ref_s) : int'(ref_s);
      act  = (mag > mcnt);
      md   = en ? {polc, ~act} : 2'd1;
      epat = en ? pat_of(md) : 6'b0;
      em   = md;
      for (int i = 0; i < 6; i++) begin
        if (!epat[i]) begin eg[i] = 1'b0; dc[i] = 0; end
        else if (dc[i] >= int'(dead)) eg[i] = 1'b1;
        else dc[i]++;
      end
      mpol = polc;
      if (!en) begin mcnt = 0; mup = 1; end
      else if (mup) begin
        if (mcnt >= int'(peak)) begin mup = 0; if (mcnt != 0) mcnt--; end
        else mcnt++;
      end else begin
        if (mcnt == 0) begin mup = 1; if (peak != 0) mcnt++; end
        else mcnt--;
      end
      r11_ok = en && (dead == 0);
      if (!en) tag = "R10";
      else if (eg != epat) tag = "R8";
      else case (md)
        2'd0: tag = "R2";
        2'd1: tag = "R3";
        2'd2: tag = "R4";
        default: tag = "R5";
      endcase
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      chk(gate == eg, tag, gate, eg);
      if (tag == "R1" || tag == "R10")
        chk(mode == em, tag, mode, em);
      else if (mode[1] != em[1])
        chk(1'b0, "R7", mode, em);
      else
        chk(mode == em, "R6", mode, em);
      chk(!(gate[0] && gate[1]) && !(gate[2] && gate[3]), "R9", gate, 0);
      if (r11_ok) chk(gate == pat_of(mode), "R11", gate, pat_of(mode));
    end
  end

  task automatic hold(int v, int n);
    ref_s = REF_W'(v);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    int r;
    r = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    en  = 1'b1;
    // directed corners with zero dead time
    hold(15, 120);
    hold(-7, 120);
    hold(0, 60);
    hold(20, 60);
    hold(21, 60);
    hold(30, 60);
    hold(-2048, 60);
    hold(-20, 60);
    // directed dead time and enable drop while gates are on
    dead = 4'd3;
    hold(12, 90);
    en = 1'b0;
    hold(12, 5);
    en = 1'b1;
    hold(-12, 90);
    // random segments
    for (int seg = 0; seg < 60; seg++) begin
      dead = DT_W'($urandom_range(0, 5));
      en = ($urandom_range(0, 7) != 0);
      hold($urandom_range(0, 60) - 30, $urandom_range(1, 50));
    end
    en = 1'b1;
    peak = 12'd7;
    for (int seg = 0; seg < 30; seg++) begin
      dead = DT_W'($urandom_range(0, 2));
      hold($urandom_range(0, 20) - 10, $urandom_range(1, 30));
    end
    finish_run();
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired (R1..R11 not completed)");
      finish_run();
    end
  end
endmodule